// File: doc/BRIEF.md
# Small RV64 Integer Execution Core

This block executes a five-instruction slice of the 64-bit RISC-V base integer set: add, sub, addi, slli and srli. It completes one instruction per clock. On each cycle it presents the program counter as a byte address, takes back four instruction bytes, decodes the R-type or I-type fields, reads up to two source registers, computes a 64-bit result and writes it to the destination register at the clock edge.

The instruction store sits outside the block and answers combinationally. Any word that is not one of the five supported encodings stops the core. The program counter freezes and a sticky flag rises. Only reset clears it. A side read port lets a test environment inspect any architectural register, so a program is normally followed by an unsupported word (for example all zeros), which parks the core so its results can be read out.

Top module: `rvl_core`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0, clears all 32 registers to 0 and clears the illegal flag.
- R2: Each supported instruction advances the fetch address by 4 at the next clock edge.
- R3: Byte lane k of `fetch_data` (bits 8k+7:8k) holds the memory byte at fetch address + k, so the instruction word is little-endian. The bytes 33 05 b5 00 execute as add x10, x10, x11.
- R4: Register 0 always reads as zero, and writes to it are discarded.
- R5: Opcode 0110011 with funct3 (bits 14:12) = 000 performs rd = rs1 + rs2 when funct7 (bits 31:25) = 0000000, and rd = rs1 - rs2 when funct7 = 0100000. Both wrap modulo 2^64. rd is bits 11:7, rs1 is bits 19:15 and rs2 is bits 24:20.
- R6: Opcode 0010011 with funct3 = 000 performs rd = rs1 + imm. The immediate is bits 31:20, sign-extended to 64 bits.
- R7: Opcode 0010011 with funct3 = 001 performs a left shift, and funct3 = 101 performs a zero-filling right shift. Both require bits 31:26 = 000000 and shift by the 6-bit amount in bits 25:20. The word 0x00155513 executes as srli x10, x10, 1.
- R8: Sources are read before the destination is written, so the same register may be both source and destination.
- R9: Any other encoding sets the illegal flag at the next clock edge and writes no register. From then on the fetch address holds still, until reset.
- R10: `dbg_data` shows the register selected by `dbg_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | output | 32 | Byte address of the current instruction |
| fetch_data | input | 32 | Four instruction bytes, lane k from address fetch_addr + k |
| dbg_addr | input | 5 | Register index for the inspection port |
| dbg_data | output | 64 | Registered contents of the selected register |
| illegal | output | 1 | Sticky flag: an unsupported encoding was met and the core is halted |

## Verification
The bench builds the core with its default parameters: 64-bit registers, 32 of them, and a 32-bit fetch address. At full width the sign-extension of negative immediates reaches the top bit, shifts up to 63 places are legal, and a zero-filling right shift of all ones is told apart from an arithmetic one. The five-bit register index covers the whole register file, so register 0 and the highest indices are reachable from real encodings.

// File: rtl/rvl_pkg.sv
package rvl_pkg;
  localparam int ILEN = 32;

  localparam logic [6:0] OPC_REG = 7'b0110011;
  localparam logic [6:0] OPC_IMM = 7'b0010011;

  localparam logic [2:0] F3_ADD = 3'b000;
  localparam logic [2:0] F3_SLL = 3'b001;
  localparam logic [2:0] F3_SRL = 3'b101;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLL,
    ALU_SRL
  } alu_op_e;

  typedef struct packed {
    alu_op_e    op;
    logic       use_imm;
    logic       illegal;
    logic [4:0] rd;
    logic [4:0] rs1;
    logic [4:0] rs2;
  } dec_t;
endpackage

// File: rtl/rvl_decode.sv
module rvl_decode
  import rvl_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [ILEN-1:0] insn,
  output dec_t            dec,
  output logic [XLEN-1:0] imm
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign f7  = insn[31:25];
  assign imm = {{(XLEN-12){insn[31]}}, insn[31:20]};

  always_comb begin
    dec         = '0;
    dec.op      = ALU_ADD;
    dec.illegal = 1'b1;
    dec.rd      = insn[11:7];
    dec.rs1     = insn[19:15];
    dec.rs2     = insn[24:20];
    case (opc)
      OPC_REG: begin
        if (f3 == F3_ADD && f7 == F7_BASE) begin
          dec.op      = ALU_ADD;
          dec.illegal = 1'b0;
        end else if (f3 == F3_ADD && f7 == F7_ALT) begin
          dec.op      = ALU_SUB;
          dec.illegal = 1'b0;
        end
      end
      OPC_IMM: begin
        dec.use_imm = 1'b1;
        case (f3)
          F3_ADD: begin
            dec.op      = ALU_ADD;
            dec.illegal = 1'b0;
          end
          F3_SLL: begin
            dec.op      = ALU_SLL;
            dec.illegal = (insn[31:26] != 6'b0);
          end
          F3_SRL: begin
            dec.op      = ALU_SRL;
            dec.illegal = (insn[31:26] != 6'b0);
          end
          default: dec.illegal = 1'b1;
        endcase
      end
      default: dec.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/rvl_alu.sv
module rvl_alu
  import rvl_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int SH_W = $clog2(XLEN)
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLL: y = a << sh;
      ALU_SRL: y = a >> sh;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rvl_regfile.sv
module rvl_regfile #(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata
);
  logic [XLEN-1:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we && waddr != '0) begin
      regs_q[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == '0) ? '0 : regs_q[raddr[g]];
  end

  // R8: a committed write is visible on the next cycle
  p_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> (regs_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rvl_core.sv
module rvl_core
  import rvl_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32,
  parameter int PC_W = 32,
  localparam int REG_AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [PC_W-1:0]   fetch_addr,
  input  logic [ILEN-1:0]   fetch_data,
  input  logic [REG_AW-1:0] dbg_addr,
  output logic [XLEN-1:0]   dbg_data,
  output logic              illegal
);
  localparam int PC_INC = ILEN / 8;
  localparam int SH_W   = $clog2(XLEN);

  logic [PC_W-1:0] pc_q;
  logic            halt_q;
  logic [XLEN-1:0] dbg_q;

  dec_t            dec;
  logic [XLEN-1:0] imm;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] alu_y;
  logic            step;

  logic [2:0][REG_AW-1:0] rf_raddr;
  logic [2:0][XLEN-1:0]   rf_rdata;

  rvl_decode #(.XLEN(XLEN)) u_dec (
    .insn (fetch_data),
    .dec  (dec),
    .imm  (imm)
  );

  assign rf_raddr = {dbg_addr, dec.rs2, dec.rs1};
  assign step     = !halt_q && !dec.illegal;

  rvl_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(3)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .raddr (rf_raddr),
    .rdata (rf_rdata),
    .we    (step),
    .waddr (dec.rd),
    .wdata (alu_y)
  );

  assign opb = dec.use_imm ? imm : rf_rdata[1];

  rvl_alu #(.XLEN(XLEN)) u_alu (
    .op (dec.op),
    .a  (rf_rdata[0]),
    .b  (opb),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      halt_q <= 1'b0;
      dbg_q  <= '0;
    end else begin
      if (step) pc_q <= pc_q + PC_W'(PC_INC);
      if (!halt_q && dec.illegal) halt_q <= 1'b1;
      dbg_q <= rf_rdata[2];
    end
  end

  assign fetch_addr = pc_q;
  assign illegal    = halt_q;
  assign dbg_data   = dbg_q;

  // R2: a supported instruction moves the fetch address by one word
  p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!illegal && !dec.illegal) |=> (fetch_addr == $past(fetch_addr) + PC_W'(PC_INC)));

  // R9: once halted, the flag and the fetch address stay put
  p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
    illegal |=> (illegal && $stable(fetch_addr)));

  // R7: a nonzero right shift always leaves the top bit clear
  p_srl_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (!dec.illegal && dec.op == ALU_SRL && opb[SH_W-1:0] != '0) |-> !alu_y[XLEN-1]);

  // R6: the extended immediate carries the sign of instruction bit 31
  p_imm_sign_r6: assert property (@(posedge clk) disable iff (rst)
    (!dec.illegal && dec.use_imm) |-> (opb[XLEN-1] == fetch_data[31]));

  // R4: inspecting register 0 always returns zero
  p_dbg_x0_r4: assert property (@(posedge clk) disable iff (rst)
    (dbg_addr == '0) |=> (dbg_data == '0));
endmodule

// File: tb/rvl_core_bench.sv
module rvl_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int MEMB = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_addr;
  logic [31:0] fetch_data;
  logic [4:0]  dbg_addr = '0;
  logic [63:0] dbg_data;
  logic        illegal;

  logic [7:0] mem [MEMB];
  logic [7:0] fa;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rvl_core u_rvl_core (
    .clk        (clk),
    .rst        (rst),
    .fetch_addr (fetch_addr),
    .fetch_data (fetch_data),
    .dbg_addr   (dbg_addr),
    .dbg_data   (dbg_data),
    .illegal    (illegal)
  );

  assign fa = fetch_addr[7:0];
  always_comb fetch_data = {mem[fa + 8'd3], mem[fa + 8'd2], mem[fa + 8'd1], mem[fa]};

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rs2, input int rs1,
                                        input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(input int imm, input int rs1, input logic [2:0] f3, input int rd);
    return {12'(imm), 5'(rs1), f3, 5'(rd), 7'b0010011};
  endfunction
  function automatic logic [31:0] addi(input int rd, input int rs1, input int imm);
    return enc_i(imm, rs1, 3'b000, rd);
  endfunction
  function automatic logic [31:0] slli(input int rd, input int rs1, input int sh);
    return enc_i(sh, rs1, 3'b001, rd);
  endfunction
  function automatic logic [31:0] srli(input int rd, input int rs1, input int sh);
    return enc_i(sh, rs1, 3'b101, rd);
  endfunction
  function automatic logic [31:0] add(input int rd, input int rs1, input int rs2);
    return enc_r(7'b0000000, rs2, rs1, 3'b000, rd);
  endfunction
  function automatic logic [31:0] sub(input int rd, input int rs1, input int rs2);
    return enc_r(7'b0100000, rs2, rs1, 3'b000, rd);
  endfunction

  localparam logic [31:0] NOP = 32'h0000_0013;

  typedef struct packed {
    logic [3:0][31:0] prog;
    logic [4:0]       rd;
    logic [63:0]      exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{ {NOP, slli(12, 11, 1), addi(11, 10, -13), addi(10, 0, 34)}, 5'd12, 64'd42 },
    '{ {NOP, 32'h00b5_0533, addi(11, 0, 3), addi(10, 0, 8)}, 5'd10, 64'd11 },
    '{ {NOP, NOP, srli(6, 5, 1), addi(5, 0, -1)}, 5'd6, 64'h7FFF_FFFF_FFFF_FFFF },
    '{ {NOP, NOP, slli(6, 5, 63), addi(5, 0, 1)}, 5'd6, 64'h8000_0000_0000_0000 },
    '{ {NOP, sub(8, 5, 7), addi(7, 0, 9), addi(5, 0, 5)}, 5'd8, 64'hFFFF_FFFF_FFFF_FFFC },
    '{ {NOP, NOP, add(9, 0, 0), addi(0, 0, 5)}, 5'd9, 64'd0 },
    '{ {NOP, NOP, NOP, addi(0, 0, 7)}, 5'd0, 64'd0 },
    '{ {NOP, NOP, add(2, 1, 1), addi(1, 0, -2048)}, 5'd2, 64'hFFFF_FFFF_FFFF_F000 },
    '{ {NOP, NOP, srli(2, 1, 0), addi(1, 0, 2047)}, 5'd2, 64'd2047 },
    '{ {NOP, NOP, addi(2, 1, 3), addi(1, 0, -1)}, 5'd2, 64'd2 },
    '{ {NOP, NOP, 32'h0015_5513, addi(10, 0, 7)}, 5'd10, 64'd3 },
    '{ {add(3, 3, 3), sub(3, 3, 4), addi(4, 0, 4), addi(3, 0, 10)}, 5'd3, 64'd12 }
  };

  function automatic string vtag(input int i);
    case (i)
      0:  return "R6 R7 addi/slli chain";
      1:  return "R3 R5 R8 little-endian add";
      2:  return "R7 srli zero fill";
      3:  return "R7 slli by 63";
      4:  return "R5 sub negative";
      5:  return "R4 write to x0 discarded";
      6:  return "R4 x0 reads zero";
      7:  return "R6 imm -2048";
      8:  return "R6 R7 imm 2047 shift 0";
      9:  return "R5 R6 wrap";
      10: return "R7 0x00155513 as srli";
      default: return "R8 same src and dest";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_prog(input logic [3:0][31:0] p);
    for (int a = 0; a < MEMB; a++) mem[a] = 8'h00;
    for (int w = 0; w < 4; w++)
      for (int b = 0; b < 4; b++) mem[4*w + b] = p[w][8*b +: 8];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_reg(input int r, output logic [63:0] v);
    dbg_addr = 5'(r);
    @(negedge clk);
    v = dbg_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R9 actual=running expected=halted");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    load_prog({NOP, NOP, NOP, NOP});
    @(negedge clk);
    @(negedge clk);
    // R1: state held in reset
    chk("R1 fetch_addr in reset", 64'(fetch_addr), 64'd0);
    chk("R1 illegal in reset", 64'(illegal), 64'd0);
    chk("R1 dbg_data in reset", dbg_data, 64'd0);

    // R2: step sequence over four nops, then halt at word 4
    rst = 1'b0;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk("R2 pc step", 64'(fetch_addr), 64'(4*k));
    end
    @(negedge clk);
    chk("R9 halt at end", 64'(illegal), 64'd1);
    chk("R9 pc frozen", 64'(fetch_addr), 64'd16);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      load_prog(VECS[i].prog);
      do_reset();
      repeat (8) @(negedge clk);
      chk({vtag(i), " R9 halted"}, 64'(illegal), 64'd1);
      chk({vtag(i), " R2 halt addr"}, 64'(fetch_addr), 64'd16);
      read_reg(int'(VECS[i].rd), v);
      chk({vtag(i), " R10 result"}, v, VECS[i].exp);
    end

    // R1: reset clears registers written by the last vector (x3=12)
    load_prog({NOP, NOP, NOP, NOP});
    mem[0] = 8'h00;
    do_reset();
    @(negedge clk);
    chk("R9 immediate halt", 64'(illegal), 64'd1);
    chk("R9 halt at 0", 64'(fetch_addr), 64'd0);
    read_reg(3, v);
    chk("R1 x3 cleared", v, 64'd0);
    read_reg(4, v);
    chk("R1 x4 cleared", v, 64'd0);

    // R9: unsupported funct7 in the middle; nothing after it runs
    load_prog({addi(3, 0, 9), enc_r(7'b0000001, 1, 1, 3'b000, 4), addi(3, 0, 1), addi(1, 0, 5)});
    do_reset();
    repeat (10) @(negedge clk);
    chk("R9 mid halt flag", 64'(illegal), 64'd1);
    chk("R9 mid halt addr", 64'(fetch_addr), 64'd8);
    read_reg(4, v);
    chk("R9 no write from illegal", v, 64'd0);
    read_reg(3, v);
    chk("R9 later instr skipped", v, 64'd1);

    // R9/R7: arithmetic right shift form is unsupported; flag timing
    load_prog({NOP, NOP, enc_i(12'h401, 5, 3'b101, 5), addi(5, 0, -8)});
    do_reset();
    @(negedge clk);
    chk("R9 flag low before illegal edge", 64'(illegal), 64'd0);
    @(negedge clk);
    chk("R9 flag high after illegal edge", 64'(illegal), 64'd1);
    repeat (3) @(negedge clk);
    chk("R9 srai form halts", 64'(fetch_addr), 64'd4);
    read_reg(5, v);
    chk("R9 srai form no write", v, 64'hFFFF_FFFF_FFFF_FFF8);
    read_reg(0, v);
    chk("R4 R10 x0 via debug", v, 64'd0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule